// File: doc/BRIEF.md
# Register-Indirect Effective Address Generator

This block turns a pointer held in one of eight 16-bit word registers into a 24-bit memory address. The low 16 bits come from the pointer, alone, with a signed displacement added, or as the pre-update value of a post-incremented pointer. The upper 8 bits come from one of four bank registers. The block picks the bank from the pointer's index. Pointers 3 and 7 use a stack bank, and a stack-select input picks which stack bank is used.

A requester presents a mode, a pointer index, a displacement, an operand size and the stack-select flag, with `req_i` high for one cycle per access. One cycle later the block returns the address, a second address for the upper byte of a word access, and a strobe. An error flag replaces the strobe if the index is not legal for the chosen mode. In post-increment mode it also reports the new pointer value, which it writes back so that the next request sees it. A separate load port preloads the word registers and the bank registers.

Top module: `ea_gen_top`

## Requirements
- R1: Pointers 0, 1, 4 and 5 take address bits 23..16 from bank slot 0, the data bank (`bank_idx_i` = 0).
- R2: Pointers 2 and 6 take address bits 23..16 from bank slot 1, the additional data bank.
- R3: Pointers 3 and 7 take address bits 23..16 from bank slot 2, the system stack bank, when `stack_sel_i` = 1, and from bank slot 3, the user stack bank, when `stack_sel_i` = 0.
- R4: In plain indirect mode (`mode_i` = 0), any pointer is accepted. Address bits 15..0 equal the pointer, and the pointer is not changed.
- R5: In 8-bit displacement mode (`mode_i` = 2), any pointer is accepted. `disp_i[7:0]` is sign-extended and added to the pointer modulo 2^16, and the pointer is not changed.
- R6: In 16-bit displacement mode (`mode_i` = 3), `disp_i` is added to the pointer modulo 2^16. Only pointers 0 to 3 are accepted, and the pointer is not changed.
- R7: In post-increment mode (`mode_i` = 1), only pointers 0 to 3 are accepted. The address is the old pointer. The pointer then grows by 2 for a word access (`word_i` = 1) or by 1 for a byte access, modulo 2^16, and `wb_valid_o`/`wb_data_o` report the new value.
- R8: `addr_hi_o` has the same bank byte as `addr_o`. Its low 16 bits are `addr_o[15:0]` + 1 modulo 2^16 for a word access, and it equals `addr_o` for a byte access.
- R9: An index from 4 to 7 in mode 1 or mode 3 raises `err_o`. It suppresses `strobe_o` and `wb_valid_o`, and the pointer keeps its value.
- R10: The outputs appear one cycle after the request. A post-increment result is seen by a request in the very next cycle.
- R11: The load port writes a word register (`rf_we_i`) or a bank register (`bank_we_i`). If it targets the same pointer as a post-increment in the same cycle, the loaded value wins.
- R12: After reset all registers are zero and `strobe_o`, `err_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Address request |
| mode_i | input | 2 | 0 plain, 1 post-increment, 2 disp8, 3 disp16 |
| idx_i | input | 3 | Pointer register index |
| disp_i | input | 16 | Displacement (low byte used in mode 2) |
| word_i | input | 1 | 1 word access, 0 byte access |
| stack_sel_i | input | 1 | 1 system stack bank, 0 user stack bank |
| rf_we_i | input | 1 | Word register load enable |
| rf_idx_i | input | 3 | Word register load index |
| rf_data_i | input | 16 | Word register load value |
| bank_we_i | input | 1 | Bank register load enable |
| bank_idx_i | input | 2 | Bank slot: 0 data, 1 additional, 2 system stack, 3 user stack |
| bank_data_i | input | 8 | Bank register load value |
| addr_o | output | 24 | Effective address |
| addr_hi_o | output | 24 | Address of the upper byte of a word access |
| strobe_o | output | 1 | Address valid |
| err_o | output | 1 | Illegal index for the mode |
| wb_valid_o | output | 1 | Pointer was post-incremented |
| wb_data_o | output | 16 | New pointer value |

## Verification
A pointer that is corrupted, or that is updated when it should not be, has no effect on the port that carries the fault. The error first shows in `addr_o` on the next request that reads the same pointer. The bench therefore sweeps every mode, index, size and stack-select combination back to back against a running arithmetic model, so each stale or wrong write-back is seen one cycle after the following access. A wrong bank choice or a wrong sign extension shows at once in the returned address. Cases near the top of the range show whether a carry leaks into the bank byte.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    MODE_IND  = 2'd0,
    MODE_PINC = 2'd1,
    MODE_D8   = 2'd2,
    MODE_D16  = 2'd3
  } ea_mode_e;

  localparam int unsigned BANK_DATA = 0;
  localparam int unsigned BANK_ADD  = 1;
  localparam int unsigned BANK_SSTK = 2;
  localparam int unsigned BANK_USTK = 3;
  localparam int unsigned NUM_BANKS = 4;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned BIDX_W   = $clog2(NUM_BANKS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [IDX_W-1:0]                  rd_idx_i,
  output logic [REG_W-1:0]                  rd_data_o,
  input  logic                              ld_we_i,
  input  logic [IDX_W-1:0]                  ld_idx_i,
  input  logic [REG_W-1:0]                  ld_data_i,
  input  logic                              upd_we_i,
  input  logic [IDX_W-1:0]                  upd_idx_i,
  input  logic [REG_W-1:0]                  upd_data_i,
  input  logic                              bank_we_i,
  input  logic [BIDX_W-1:0]                 bank_idx_i,
  input  logic [BANK_W-1:0]                 bank_data_i,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  banks_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (ld_we_i && ld_idx_i == IDX_W'(g)) regs_q[g] <= ld_data_i;   // load wins
      else if (upd_we_i && upd_idx_i == IDX_W'(g)) regs_q[g] <= upd_data_i;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) banks_o[b] <= '0;
      else if (bank_we_i && bank_idx_i == BIDX_W'(b)) banks_o[b] <= bank_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_idx_i];
endmodule

// File: rtl/ea_bank_sel.sv
module ea_bank_sel #(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic                              stack_sel_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  banks_i,
  output logic [BANK_W-1:0]                 bank_o
);
  import ea_pkg::*;
  // low two index bits pick the bank class
  always_comb begin
    unique case (idx_i[1:0])
      2'd2:    bank_o = banks_i[BANK_ADD];
      2'd3:    bank_o = stack_sel_i ? banks_i[BANK_SSTK] : banks_i[BANK_USTK];
      default: bank_o = banks_i[BANK_DATA];
    endcase
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc #(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned NARROW_REGS = 4,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS)
) (
  input  logic [1:0]       mode_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] ptr_i,
  input  logic [REG_W-1:0] disp_i,
  input  logic             word_i,
  output logic             legal_o,
  output logic             pinc_o,
  output logic [REG_W-1:0] lo_o,
  output logic [REG_W-1:0] lo_hi_o,
  output logic [REG_W-1:0] ptr_next_o
);
  import ea_pkg::*;
  ea_mode_e         mode;
  logic [REG_W-1:0] off;
  logic             narrow;

  assign mode   = ea_mode_e'(mode_i);
  assign narrow = (mode == MODE_PINC) || (mode == MODE_D16);

  always_comb begin
    unique case (mode)
      MODE_D8:  off = {{(REG_W-8){disp_i[7]}}, disp_i[7:0]};
      MODE_D16: off = disp_i;
      default:  off = '0;
    endcase
  end

  assign legal_o    = !narrow || (32'(idx_i) < NARROW_REGS);
  assign pinc_o     = (mode == MODE_PINC);
  assign lo_o       = ptr_i + off;
  assign lo_hi_o    = word_i ? lo_o + REG_W'(1) : lo_o;
  assign ptr_next_o = ptr_i + (word_i ? REG_W'(2) : REG_W'(1));
endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top #(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned BANK_W      = 8,
  parameter int unsigned NARROW_REGS = 4,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS),
  localparam int unsigned ADDR_W     = REG_W + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [REG_W-1:0]  disp_i,
  input  logic              word_i,
  input  logic              stack_sel_i,
  input  logic              rf_we_i,
  input  logic [IDX_W-1:0]  rf_idx_i,
  input  logic [REG_W-1:0]  rf_data_i,
  input  logic              bank_we_i,
  input  logic [1:0]        bank_idx_i,
  input  logic [BANK_W-1:0] bank_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] addr_hi_o,
  output logic              strobe_o,
  output logic              err_o,
  output logic              wb_valid_o,
  output logic [REG_W-1:0]  wb_data_o
);
  import ea_pkg::*;

  logic [REG_W-1:0]                 ptr, lo, lo_hi, ptr_next;
  logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
  logic [BANK_W-1:0]                bank;
  logic                             legal, pinc, go;

  assign go = req_i && legal;

  ea_regfile #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)
  ) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (idx_i),
    .rd_data_o  (ptr),
    .ld_we_i    (rf_we_i),
    .ld_idx_i   (rf_idx_i),
    .ld_data_i  (rf_data_i),
    .upd_we_i   (go && pinc),
    .upd_idx_i  (idx_i),
    .upd_data_i (ptr_next),
    .bank_we_i  (bank_we_i),
    .bank_idx_i (bank_idx_i),
    .bank_data_i(bank_data_i),
    .banks_o    (banks)
  );

  ea_bank_sel #(
    .NUM_REGS(NUM_REGS), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)
  ) u_bank (
    .idx_i      (idx_i),
    .stack_sel_i(stack_sel_i),
    .banks_i    (banks),
    .bank_o     (bank)
  );

  ea_calc #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .NARROW_REGS(NARROW_REGS)
  ) u_calc (
    .mode_i    (mode_i),
    .idx_i     (idx_i),
    .ptr_i     (ptr),
    .disp_i    (disp_i),
    .word_i    (word_i),
    .legal_o   (legal),
    .pinc_o    (pinc),
    .lo_o      (lo),
    .lo_hi_o   (lo_hi),
    .ptr_next_o(ptr_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      addr_hi_o  <= '0;
      strobe_o   <= 1'b0;
      err_o      <= 1'b0;
      wb_valid_o <= 1'b0;
      wb_data_o  <= '0;
    end else begin
      strobe_o   <= go;
      err_o      <= req_i && !legal;
      wb_valid_o <= go && pinc;
      if (go) begin
        addr_o    <= {bank, lo};
        addr_hi_o <= {bank, lo_hi};
        wb_data_o <= ptr_next;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned BANK_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned ADDR_W  = REG_W + BANK_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [1:0]        mode_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] addr_hi_o,
  input logic              strobe_o,
  input logic              err_o,
  input logic              wb_valid_o,
  input logic [REG_W-1:0]  wb_data_o
);
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_o && err_o)); // R9

  AST_NARROW_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (mode_i == 2'd1 || mode_i == 2'd3) && idx_i[IDX_W-1]
    |=> err_o && !strobe_o && !wb_valid_o); // R9

  AST_NO_REQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !strobe_o && !err_o); // R10

  AST_WB_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> strobe_o); // R7

  AST_WB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_data_o == addr_o[REG_W-1:0] + REG_W'(1)) ||
                   (wb_data_o == addr_o[REG_W-1:0] + REG_W'(2))); // R7

  AST_HI_SAME_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> addr_hi_o[ADDR_W-1:REG_W] == addr_o[ADDR_W-1:REG_W]); // R8

  AST_HI_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (addr_hi_o == addr_o) ||
                 (addr_hi_o[REG_W-1:0] == addr_o[REG_W-1:0] + REG_W'(1))); // R8
endmodule

bind ea_gen_top ea_gen_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .BANK_W(BANK_W)
) u_chk (.*);

// File: tb/ea_gen_top_tb.sv
`timescale 1ns/1ps
module ea_gen_top_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, word_i = 1'b0, stack_sel_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [2:0]  idx_i = '0;
  logic [15:0] disp_i = '0;
  logic        rf_we_i = 1'b0, bank_we_i = 1'b0;
  logic [2:0]  rf_idx_i = '0;
  logic [15:0] rf_data_i = '0;
  logic [1:0]  bank_idx_i = '0;
  logic [7:0]  bank_data_i = '0;
  logic [23:0] addr_o, addr_hi_o;
  logic        strobe_o, err_o, wb_valid_o;
  logic [15:0] wb_data_o;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_reg [8];
  logic [7:0]  m_bank [4];

  always #4 clk_i = ~clk_i;

  ea_gen_top u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_reg(input int i, input logic [15:0] v);
    rf_we_i = 1'b1; rf_idx_i = 3'(i); rf_data_i = v;
    @(negedge clk_i); rf_we_i = 1'b0;
    m_reg[i] = v;
  endtask

  task automatic load_bank(input int b, input logic [7:0] v);
    bank_we_i = 1'b1; bank_idx_i = 2'(b); bank_data_i = v;
    @(negedge clk_i); bank_we_i = 1'b0;
    m_bank[b] = v;
  endtask

  // one request; inputs driven at negedge, outputs sampled at the next negedge
  task automatic access(input int md, input int ix, input logic [15:0] dp,
                        input logic w, input logic ss, input string tag);
    logic        legal;
    logic [15:0] base, off, lo, lohi;
    logic [7:0]  bk;
    legal = !((md == 1 || md == 3) && ix >= 4);
    base  = m_reg[ix];
    case (ix % 4)
      2: bk = m_bank[1];
      3: bk = ss ? m_bank[2] : m_bank[3];
      default: bk = m_bank[0];
    endcase
    off  = (md == 2) ? {{8{dp[7]}}, dp[7:0]} : (md == 3) ? dp : 16'h0;
    lo   = base + off;
    lohi = w ? lo + 16'd1 : lo;
    req_i = 1'b1; mode_i = 2'(md); idx_i = 3'(ix); disp_i = dp; word_i = w; stack_sel_i = ss;
    @(negedge clk_i);
    req_i = 1'b0;
    chk({tag, " R9 err"}, 32'(err_o), 32'(!legal));
    chk({tag, " R9 strobe"}, 32'(strobe_o), 32'(legal));
    chk({tag, " R7 wb_valid"}, 32'(wb_valid_o), 32'(legal && md == 1));
    if (legal) begin
      chk({tag, " R1 R2 R3 R4 R5 R6 addr"}, 32'(addr_o), {8'h0, bk, lo});
      chk({tag, " R8 addr_hi"}, 32'(addr_hi_o), {8'h0, bk, lohi});
      if (md == 1) begin
        m_reg[ix] = base + (w ? 16'd2 : 16'd1);
        chk({tag, " R7 wb_data"}, 32'(wb_data_o), 32'(m_reg[ix]));
      end
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    foreach (m_reg[i]) m_reg[i] = '0;
    foreach (m_bank[i]) m_bank[i] = '0;
    repeat (2) @(negedge clk_i);
    // R12 reset state
    chk("R12 strobe", 32'(strobe_o), 0);
    chk("R12 err", 32'(err_o), 0);
    chk("R12 wb_valid", 32'(wb_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    access(0, 5, 16'h0, 1'b0, 1'b0, "R12 zero regs");

    // worked examples: bank 78, pointer D30F
    load_bank(0, 8'h78);
    load_reg(1, 16'hD30F);
    access(3, 1, 16'h0010, 1'b1, 1'b0, "R6 disp16 example");
    access(1, 1, 16'h0, 1'b1, 1'b0, "R7 pinc word example");
    chk("R7 example new ptr", 32'(m_reg[1]), 32'h0000D311);
    access(0, 1, 16'h0, 1'b0, 1'b0, "R10 next-cycle visibility");

    // wrap at top of range: carry never reaches the bank
    load_reg(0, 16'hFFFF);
    access(1, 0, 16'h0, 1'b1, 1'b0, "R7 R8 pinc wrap");
    access(0, 0, 16'h0, 1'b0, 1'b0, "R7 after wrap");
    load_reg(2, 16'hFFF8);
    load_bank(1, 8'h3C);
    access(3, 2, 16'h0010, 1'b0, 1'b0, "R6 disp16 wrap");
    access(2, 2, 16'h0080, 1'b1, 1'b0, "R5 disp8 negative");

    // R11 load beats post-increment on the same pointer
    req_i = 1'b1; mode_i = 2'd1; idx_i = 3'd3; word_i = 1'b0; stack_sel_i = 1'b1;
    rf_we_i = 1'b1; rf_idx_i = 3'd3; rf_data_i = 16'h1234;
    @(negedge clk_i);
    req_i = 1'b0; rf_we_i = 1'b0;
    chk("R11 collide strobe", 32'(strobe_o), 1);
    m_reg[3] = 16'h1234;
    access(0, 3, 16'h0, 1'b0, 1'b1, "R11 load wins");

    // distinct banks and pointers, then full sweep
    load_bank(2, 8'hA5);
    load_bank(3, 8'h5A);
    for (int i = 0; i < 8; i++) load_reg(i, 16'(16'h1111 * i + 16'h00F0 + (i == 7 ? 16'h7000 : 0)));
    for (int md = 0; md < 4; md++)
      for (int ix = 0; ix < 8; ix++)
        for (int ss = 0; ss < 2; ss++)
          for (int w = 0; w < 2; w++)
            for (int d = 0; d < 4; d++) begin
              logic [15:0] dp;
              case (d)
                0: dp = 16'h0005;
                1: dp = 16'h00F0;
                2: dp = 16'h8001;
                default: dp = 16'h7FFF;
              endcase
              access(md, ix, dp, w[0], ss[0], "sweep");
            end
    // R9 illegal pointers left untouched
    for (int ix = 4; ix < 8; ix++) access(0, ix, 16'h0, 1'b0, 1'b0, "R9 reg unchanged");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule